// File: doc/BRIEF.md
# Set-Associative Instruction TLB

This block turns instruction-fetch virtual addresses into physical addresses through a small set-associative table. Every way of every set holds two words loaded by software: a match word (tag, valid flag, usage age) and a translate word (physical page number, cache-inhibit flag, user-execute and supervisor-execute permissions). A fetch lookup returns, one cycle later, the physical address together with a cache-inhibit flag, a TLB-miss exception or an instruction page-fault exception. A hit also ages the usage counters of its set. The block does no table walking and no refill. Software handles a miss and writes the entry back through the write port.

When translation is switched off, or the unit is marked as not implemented, the block passes addresses through unchanged. In that case cache-inhibit depends only on the top address bit. A second, purely combinational peek port answers the same question as a lookup, with no exception and no change to any state, so debug logic can use it. A read port returns any stored word, and a constant configuration word gives the table geometry.

Top module: `itlb_xlate`

## Requirements
- R1: With `mmu_en` or `mmu_present` low, a lookup returns `lk_paddr` equal to the virtual address one cycle after `lk_req`, with `lk_ci` equal to the top address bit (set for addresses at or above 0x80000000) and no exception.
- R2: The set index is the virtual address bits just above the page offset (`lk_vaddr[PAGE_BITS +: log2(NSETS)]`) and the tag is every bit above those. In a match word, bit 0 is valid, bits 7:6 are the age and the tag occupies the same bit positions as in the address.
- R3: On a hit, `lk_paddr` is the translate word with its page-offset bits replaced by the offset of the virtual address, and `lk_ci` is bit 1 of the translate word.
- R4: When several valid ways of a set carry the matching tag, the highest-numbered way supplies the translation.
- R5: On a hit, `lk_pfault` is raised when `sup_mode` is high and translate bit 7 is clear, or when `sup_mode` is low and translate bit 6 is clear. The translated address is still reported.
- R6: A miss raises `lk_miss` with `lk_paddr` zero, `lk_ci` low and `lk_pfault` low, and it leaves every age unchanged.
- R7: On a hit, including a hit that faults, every other way in the set with a nonzero age drops by one, the hit way's age becomes `USTATES-1`, and ages in other sets do not change.
- R8: `pk_paddr` gives the virtual address when translation is bypassed, the translated address on a permitted hit, and zero on a miss or permission failure. A peek changes no stored word and raises no exception.
- R9: A write becomes visible on the read port and to lookups from the next cycle on. A lookup in the same cycle uses the old contents. If that lookup hits the written entry, the written word replaces the age update for that entry.
- R10: `cfg_word` holds `NWAYS-1` in bits 1:0 and log2(`NSETS`) in bits 6:3, with all other bits zero.
- R11: `lk_valid` is high exactly in the cycle after a cycle with `lk_req` high, and `lk_miss`/`lk_pfault` are raised only in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en | input | 1 | Translation enable |
| mmu_present | input | 1 | Unit implemented; low forces bypass |
| sup_mode | input | 1 | Supervisor privilege for the permission check |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | 0 = match word, 1 = translate word |
| wr_way | input | WAY_W | Way being written |
| wr_set | input | SET_W | Set being written |
| wr_data | input | ADDR_W | Word written |
| rd_sel | input | 1 | 0 = match word, 1 = translate word |
| rd_way | input | WAY_W | Way being read |
| rd_set | input | SET_W | Set being read |
| rd_data | output | ADDR_W | Stored word (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | ADDR_W | Lookup virtual address |
| lk_valid | output | 1 | Lookup result valid |
| lk_paddr | output | ADDR_W | Physical address |
| lk_ci | output | 1 | Cache-inhibit |
| lk_miss | output | 1 | TLB-miss exception |
| lk_pfault | output | 1 | Instruction page-fault exception |
| pk_vaddr | input | ADDR_W | Peek virtual address |
| pk_paddr | output | ADDR_W | Peek physical address or zero |
| cfg_word | output | 32 | Geometry word |

## Verification
The bench loads every way of every set with distinct tags, page numbers, initial ages and permission bits. For each entry it looks up three page offsets under both privilege levels, so offset merging, per-entry cache-inhibit, the choice of permission bit and age saturation can each be seen apart. Pass-through addresses on both sides of 0x80000000 show the address rule for cache-inhibit separately from the translate-word flag. Absent tags and invalidated entries separate a miss from a fault. A duplicated tag shows which way wins. A write that lands in the same cycle as a lookup to the same entry tells old-content lookup apart from write precedence. Peeks made before each lookup, followed by full age read-backs, show that peeking leaves no trace.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    // match word fields
    localparam int MW_VALID   = 0;
    localparam int MW_AGE_LSB = 6;
    localparam int AGE_W      = 2;
    // translate word fields
    localparam int TW_CI      = 1;
    localparam int TW_UEXE    = 6;
    localparam int TW_SEXE    = 7;

    typedef enum logic {
        SEL_MATCH = 1'b0,
        SEL_XLATE = 1'b1
    } entry_sel_e;
endpackage

// File: rtl/itlb_hit_sel.sv
module itlb_hit_sel #(
    parameter int NWAYS = 2,
    parameter int TAG_W = 17,
    parameter int WAY_W = 1
) (
    input  logic [NWAYS-1:0]            vld,
    input  logic [NWAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            cmp_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);
    logic [NWAYS-1:0] eq;

    for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == cmp_tag);
    end

    // ascending scan: the last (highest) matching way is kept
    always_comb begin
        way = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (eq[i]) way = WAY_W'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/itlb_age_upd.sv
module itlb_age_upd #(
    parameter int NWAYS   = 2,
    parameter int USTATES = 4,
    parameter int WAY_W   = 1
) (
    input  logic [NWAYS-1:0][itlb_pkg::AGE_W-1:0] age_in,
    input  logic [WAY_W-1:0]                      hit_way,
    output logic [NWAYS-1:0][itlb_pkg::AGE_W-1:0] age_out
);
    localparam int AW = itlb_pkg::AGE_W;
    localparam logic [AW-1:0] AGE_TOP = AW'(USTATES - 1);

    for (genvar g = 0; g < NWAYS; g++) begin : g_age
        always_comb begin
            if (hit_way == WAY_W'(g))
                age_out[g] = AGE_TOP;
            else if (age_in[g] != '0)
                age_out[g] = age_in[g] - AW'(1);
            else
                age_out[g] = '0;
        end
    end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int NSETS     = 4,
    parameter int NWAYS     = 2,
    parameter int USTATES   = 4,
    localparam int SET_W    = $clog2(NSETS),
    localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_en,
    input  logic              mmu_present,
    input  logic              sup_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [SET_W-1:0]  rd_set,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic              lk_ci,
    output logic              lk_miss,
    output logic              lk_pfault,
    input  logic [ADDR_W-1:0] pk_vaddr,
    output logic [ADDR_W-1:0] pk_paddr,
    output logic [31:0]       cfg_word
);
    localparam int TAG_LSB = PAGE_BITS + SET_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    typedef logic [NWAYS-1:0][NSETS-1:0][ADDR_W-1:0] table_t;

    typedef struct packed {
        table_t              mw;
        table_t              tw;
        logic                vld;
        logic [ADDR_W-1:0]   pa;
        logic                ci;
        logic                miss;
        logic                pf;
    } state_t;

    state_t st_d, st_q;

    logic bypass;
    assign bypass = !(mmu_en && mmu_present);

    // ---------------- address split ----------------
    logic [SET_W-1:0] lk_set, pk_set;
    logic [TAG_W-1:0] lk_tag, pk_tag;
    assign lk_set = lk_vaddr[PAGE_BITS +: SET_W];
    assign pk_set = pk_vaddr[PAGE_BITS +: SET_W];
    assign lk_tag = lk_vaddr[ADDR_W-1:TAG_LSB];
    assign pk_tag = pk_vaddr[ADDR_W-1:TAG_LSB];

    // ---------------- per-way fields of the addressed set ----------------
    logic [NWAYS-1:0]            lk_vld, pk_vld;
    logic [NWAYS-1:0][TAG_W-1:0] lk_tags, pk_tags;
    logic [NWAYS-1:0][AGE_W-1:0] lk_ages, new_ages;

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        assign lk_vld[g]  = st_q.mw[g][lk_set][MW_VALID];
        assign lk_tags[g] = st_q.mw[g][lk_set][ADDR_W-1:TAG_LSB];
        assign lk_ages[g] = st_q.mw[g][lk_set][MW_AGE_LSB +: AGE_W];
        assign pk_vld[g]  = st_q.mw[g][pk_set][MW_VALID];
        assign pk_tags[g] = st_q.mw[g][pk_set][ADDR_W-1:TAG_LSB];
    end

    logic             lk_hit, pk_hit;
    logic [WAY_W-1:0] lk_way, pk_way;

    itlb_hit_sel #(.NWAYS(NWAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_sel_lk (
        .vld(lk_vld), .tags(lk_tags), .cmp_tag(lk_tag), .hit(lk_hit), .way(lk_way)
    );

    itlb_hit_sel #(.NWAYS(NWAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_sel_pk (
        .vld(pk_vld), .tags(pk_tags), .cmp_tag(pk_tag), .hit(pk_hit), .way(pk_way)
    );

    itlb_age_upd #(.NWAYS(NWAYS), .USTATES(USTATES), .WAY_W(WAY_W)) u_age (
        .age_in(lk_ages), .hit_way(lk_way), .age_out(new_ages)
    );

    // ---------------- translate words of the hit ways ----------------
    logic [ADDR_W-1:0] lk_tw, pk_tw;
    logic              lk_perm, pk_perm;
    assign lk_tw   = st_q.tw[lk_way][lk_set];
    assign pk_tw   = st_q.tw[pk_way][pk_set];
    assign lk_perm = sup_mode ? lk_tw[TW_SEXE] : lk_tw[TW_UEXE];
    assign pk_perm = sup_mode ? pk_tw[TW_SEXE] : pk_tw[TW_UEXE];

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.vld  = lk_req;
        st_d.miss = 1'b0;
        st_d.pf   = 1'b0;
        if (lk_req) begin
            if (bypass) begin
                st_d.pa = lk_vaddr;
                st_d.ci = lk_vaddr[ADDR_W-1];
            end else if (lk_hit) begin
                st_d.pa = {lk_tw[ADDR_W-1:PAGE_BITS], lk_vaddr[PAGE_BITS-1:0]};
                st_d.ci = lk_tw[TW_CI];
                st_d.pf = !lk_perm;
                for (int w = 0; w < NWAYS; w++) begin
                    st_d.mw[w][lk_set][MW_AGE_LSB +: AGE_W] = new_ages[w];
                end
            end else begin
                st_d.pa   = '0;
                st_d.ci   = 1'b0;
                st_d.miss = 1'b1;
            end
        end
        // software write overrides any age update on the same entry
        if (wr_en) begin
            if (entry_sel_e'(wr_sel) == SEL_XLATE)
                st_d.tw[wr_way][wr_set] = wr_data;
            else
                st_d.mw[wr_way][wr_set] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    assign lk_valid  = st_q.vld;
    assign lk_paddr  = st_q.pa;
    assign lk_ci     = st_q.ci;
    assign lk_miss   = st_q.miss;
    assign lk_pfault = st_q.pf;

    assign rd_data = (entry_sel_e'(rd_sel) == SEL_XLATE) ? st_q.tw[rd_way][rd_set]
                                                        : st_q.mw[rd_way][rd_set];

    always_comb begin
        if (bypass)
            pk_paddr = pk_vaddr;
        else if (pk_hit && pk_perm)
            pk_paddr = {pk_tw[ADDR_W-1:PAGE_BITS], pk_vaddr[PAGE_BITS-1:0]};
        else
            pk_paddr = '0;
    end

    always_comb begin
        cfg_word      = '0;
        cfg_word[1:0] = 2'(NWAYS - 1);
        cfg_word[6:3] = 4'(SET_W);
    end
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int WAY_W  = 1,
    parameter int SET_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mmu_en,
    input logic              mmu_present,
    input logic              wr_en,
    input logic              rd_sel,
    input logic [WAY_W-1:0]  rd_way,
    input logic [SET_W-1:0]  rd_set,
    input logic [ADDR_W-1:0] rd_data,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_paddr,
    input logic              lk_ci,
    input logic              lk_miss,
    input logic              lk_pfault
);
    a_r1_bypass_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !(mmu_en && mmu_present)) |=>
            (lk_paddr == $past(lk_vaddr)) && (lk_ci == $past(lk_vaddr[ADDR_W-1]))
            && !lk_miss && !lk_pfault);

    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0) && !lk_ci && !lk_pfault);

    a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lk_valid == $past(lk_req)));

    a_r11_exc_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_pfault) |-> lk_valid);

    a_r9_idle_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_req && !wr_en) |=>
            (!$stable(rd_sel) || !$stable(rd_way) || !$stable(rd_set) || $stable(rd_data)));
endmodule

bind itlb_xlate itlb_xlate_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W), .SET_W(SET_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .mmu_present(mmu_present),
    .wr_en(wr_en), .rd_sel(rd_sel), .rd_way(rd_way), .rd_set(rd_set), .rd_data(rd_data),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_valid(lk_valid), .lk_paddr(lk_paddr),
    .lk_ci(lk_ci), .lk_miss(lk_miss), .lk_pfault(lk_pfault)
);

// File: tb/tb_itlb_xlate.sv
`timescale 1ns/1ps
module tb_itlb_xlate;
    localparam int NS = 4, NW = 2, PB = 13, TL = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mmu_en = 1'b0, mmu_present = 1'b0, sup_mode = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [0:0] wr_way = '0, rd_way = '0;
    logic [1:0] wr_set = '0, rd_set = '0;
    logic [31:0] wr_data = '0, rd_data, lk_vaddr = '0, lk_paddr, pk_vaddr = '0, pk_paddr, cfg_word;
    logic rd_sel = 1'b0, lk_req = 1'b0, lk_valid, lk_ci, lk_miss, lk_pfault;

    int nchk = 0, nerr = 0;
    logic [31:0] mw_m [NW][NS];
    logic [31:0] tw_m [NW][NS];

    always #4 clk = ~clk;

    itlb_xlate dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit byp();
        return !(mmu_en && mmu_present);
    endfunction

    function automatic int find_way(input logic [31:0] va);
        int s = int'((va >> PB) % NS);
        int hw = -1;
        for (int w = 0; w < NW; w++)
            if (mw_m[w][s][0] && ((mw_m[w][s] >> TL) == (va >> TL))) hw = w;
        return hw;
    endfunction

    function automatic logic [31:0] xl(input int w, input logic [31:0] va);
        int s = int'((va >> PB) % NS);
        return {tw_m[w][s][31:PB], va[PB-1:0]};
    endfunction

    function automatic bit perm_ok(input int w, input logic [31:0] va);
        int s = int'((va >> PB) % NS);
        return sup_mode ? tw_m[w][s][7] : tw_m[w][s][6];
    endfunction

    task automatic check_ages(input string req);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                rd_sel = 1'b0; rd_way = 1'(w); rd_set = 2'(s);
                #1;
                chk(req, rd_data, mw_m[w][s]);
            end
    endtask

    task automatic do_write(input int w, input int s, input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_way = 1'(w); wr_set = 2'(s); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) tw_m[w][s] = d; else mw_m[w][s] = d;
    endtask

    task automatic apply_lru(input int s, input int hw);
        for (int w = 0; w < NW; w++) begin
            logic [1:0] a = mw_m[w][s][7:6];
            if (w == hw) a = 2'd3;
            else if (a != 0) a = a - 2'd1;
            mw_m[w][s][7:6] = a;
        end
    endtask

    // peek first (R8), then a full lookup checked against the bench model
    task automatic lookup(input logic [31:0] va, input string tag);
        int hw = find_way(va);
        int s = int'((va >> PB) % NS);
        logic [31:0] epa, epk;
        bit eci, emiss, epf;
        if (byp()) begin
            epa = va; eci = va[31]; emiss = 0; epf = 0; epk = va;
        end else if (hw >= 0) begin
            epa = xl(hw, va); eci = tw_m[hw][s][1]; emiss = 0; epf = !perm_ok(hw, va);
            epk = epf ? 32'h0 : epa;
        end else begin
            epa = 0; eci = 0; emiss = 1; epf = 0; epk = 0;
        end
        @(negedge clk);
        pk_vaddr = va;
        #1;
        chk({"R8 peek ", tag}, pk_paddr, epk);
        lk_req = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_req = 1'b0;
        chk({"R11 valid ", tag}, 32'(lk_valid), 32'd1);
        chk({"R3 paddr ", tag}, lk_paddr, epa);
        chk({"R3 ci ", tag}, 32'(lk_ci), 32'(eci));
        chk({"R6 miss ", tag}, 32'(lk_miss), 32'(emiss));
        chk({"R5 pfault ", tag}, 32'(lk_pfault), 32'(epf));
        if (!byp() && hw >= 0) apply_lru(s, hw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin mw_m[w][s] = 0; tw_m[w][s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R11 reset valid", 32'(lk_valid), 32'd0);
        chk("R6 reset miss", 32'(lk_miss), 32'd0);
        chk("R10 cfg word", cfg_word, 32'h0000_0011);
        check_ages("R9 reset table");

        // R1 bypass: translation disabled, then unit absent
        mmu_present = 1'b1; mmu_en = 1'b0;
        lookup(32'h0000_0000, "R1 byp 0");
        lookup(32'h7FFF_FFFF, "R1 byp below");
        lookup(32'h8000_0000, "R1 byp edge");
        lookup(32'hFFFF_FFFF, "R1 byp top");
        mmu_en = 1'b1; mmu_present = 1'b0;
        lookup(32'h8000_1234, "R1 absent");
        lookup(32'h1234_5678, "R1 absent low");
        @(negedge clk);
        chk("R11 valid drop", 32'(lk_valid), 32'd0);

        // enabled, empty table: all misses
        mmu_present = 1'b1;
        lookup(32'h0000_2000, "R6 empty");
        lookup(32'hABCD_E123, "R6 empty2");
        check_ages("R6 ages after miss");

        // R2 load: tag = 2s+w+1, age = w, ppn = 0x100+2s+w, ci = w, uexe off in set 1
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                do_write(w, s, 1'b0, (32'(s*2+w+1) << TL) | (32'(w) << 6) | 32'h1);
                do_write(w, s, 1'b1, (32'(32'h100 + s*2 + w) << PB) | (32'(w) << 1)
                                     | (32'(s != 1) << 6) | 32'h80);
            end
        check_ages("R9 write visible");

        // R2/R3/R5/R7 sweep over both privileges, all entries, three offsets
        for (int p = 0; p < 2; p++) begin
            sup_mode = p[0];
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    lookup((32'(s*2+w+1) << TL) | (32'(s) << PB) | 32'h0000, "R2 sweep");
                    lookup((32'(s*2+w+1) << TL) | (32'(s) << PB) | 32'h1FFF, "R3 sweep");
                    lookup((32'(s*2+w+1) << TL) | (32'(s) << PB) | 32'h0ABC, "R7 sweep");
                end
            check_ages("R7 ages");
            // tag that belongs to another set: miss
            lookup((32'd3 << TL) | (32'd0 << PB), "R2 wrong set");
            check_ages("R6 ages kept");
        end

        // R5 explicit fault in user mode on set 1
        sup_mode = 1'b0;
        lookup((32'd3 << TL) | (32'd1 << PB) | 32'h10, "R5 user fault");
        chk("R5 fault paddr", lk_paddr, (32'h102 << PB) | 32'h10);
        check_ages("R7 ages after fault");

        // R4: duplicate tag in set 2, way 1 must win
        do_write(0, 2, 1'b0, (32'd6 << TL) | 32'h1);
        lookup((32'd6 << TL) | (32'd2 << PB) | 32'h44, "R4 dup");
        chk("R4 highest way", lk_paddr, (32'h105 << PB) | 32'h44);
        check_ages("R7 dup ages");

        // invalidated entry misses
        do_write(1, 2, 1'b0, (32'd6 << TL));
        do_write(0, 2, 1'b0, (32'd6 << TL));
        lookup((32'd6 << TL) | (32'd2 << PB), "R2 invalid");

        // R9: write coinciding with a hitting lookup on the same entry
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = (32'd7 << TL) | (32'd3 << PB) | 32'h8;
        wr_en = 1'b1; wr_sel = 1'b0; wr_way = 1'b0; wr_set = 2'd3;
        wr_data = (32'd9 << TL) | (32'd1 << 6) | 32'h1;
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0;
        chk("R9 old contents hit", 32'(lk_miss), 32'd0);
        chk("R9 old paddr", lk_paddr, (32'h106 << PB) | 32'h8);
        apply_lru(3, 0);
        mw_m[0][3] = (32'd9 << TL) | (32'd1 << 6) | 32'h1;
        check_ages("R9 write wins");
        lookup((32'd7 << TL) | (32'd3 << PB), "R9 old tag gone");
        lookup((32'd9 << TL) | (32'd3 << PB), "R9 new tag");

        // R1 peek in bypass
        mmu_en = 1'b0;
        lookup(32'h9000_0004, "R8 byp");
        mmu_en = 1'b1;
        check_ages("R8 peek no change");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule